// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Atomic Set/Clear Controls

This block is a bank of sixteen general-purpose I/O pins with a small register interface. Every per-pin control register is written with one 32-bit word. The low half of the word turns selected pin bits on, and the high half turns selected pin bits off. Software can therefore change one pin without reading the register first, and two agents can never overwrite each other's bits.

Each pin has several controls: output value, output driver enable, input receiver enable, input invert, input filter enable, event enable, event counter enable and edge polarity. Pin inputs are synchronized first. They are then gated by the receiver enable, optionally inverted, and optionally debounced by a glitch filter whose length is programmable. Finally they feed an edge detector.

Rising and falling events are recorded in two status registers, and software clears a status bit by writing 1 to it. A single interrupt output is raised while any status bit of an event-enabled pin is pending. A readback register returns the synchronized pin levels.

Top module: `gpio_atomic_bank`

## Requirements
- R1: A write to a control register (addresses 0 to 7) sets pin bit n for each 1 in data bit n (n = 0..15), and clears pin bit n for each 1 in data bit n+16. Pin bits written as 0 in both halves keep their value.
- R2: When a set bit and its matching clear bit are both 1 in one write, the pin bit ends up 0.
- R3: Reading any register returns its value in bits 15:0 and zero in bits 31:16. `pin_out` follows the output value register (address 0) and `pin_oe` follows the output enable register (address 1). All registers reset to zero.
- R4: A pin whose input enable bit (address 2) is 0 is sensed as level 0. It reads 0 in the readback register and produces no edges of its own.
- R5: The readback register (address 10) shows a pin change two clock edges after the change. Reading it changes no state.
- R6: With its polarity bit (address 7) clear, a pin's rising sensed edge sets its bit in the rise status register (address 8). With the polarity bit set, a falling sensed edge sets its bit in the fall status register (address 9). Without filtering, the status bit is set on the third clock edge after the pin changes.
- R7: The invert bit (address 3) flips a pin's sensed level before filtering and edge detection. The readback register does not see the invert.
- R8: No status bit is set for a pin whose event enable bit (address 5) is 0.
- R9: Writing 1 to a bit of a status register clears that bit, and writing 0 leaves it unchanged. An edge that arrives in the same cycle as the clear wins, and the bit stays set.
- R10: `irq` is 1 exactly when some pin has its event enable set and has a rise or fall status bit pending.
- R11: With its filter enable bit (address 4) set and a nonzero filter amount A (address 11, plain write), a pin's new sensed level is accepted only after it has held for A consecutive cycles. Shorter pulses are dropped. With A = 0 or the filter disabled, no delay is added.
- R12: The event counter enable register is address 6. Addresses 12 to 15 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 32 | Write data (set half low, clear half high) |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| pin_in | input | 16 | Pad input levels, asynchronous |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output driver enables |
| irq | output | 1 | Merged event interrupt |

## Verification
The bench targets simultaneous set and clear of the same bit. A design that gives set priority there leaves the pin on. It also checks untouched bits across random writes, where a read-modify-write slip corrupts neighbouring pins.

Edge tests mix invert, polarity, receiver enable and event enable at random. A design that inverts after edge detection, or that records events for disabled pins, produces wrong rise and fall status. The bench also checks write-zero on status registers, which would wrongly clear a pin if handled as a plain write.

The filter is driven with a pulse one cycle shorter than the amount, which must vanish, and with a held level, which must appear exactly A cycles late. An off-by-one counter lets the pulse through or shifts the event by a cycle.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
// Package: register address map and shared constants for the GPIO bank.
// Assumes a 4-bit word address space; unused addresses read as zero.
package gpio_bank_pkg;
    typedef enum logic [3:0] {
        A_OUT_VAL  = 4'd0,
        A_OUT_EN   = 4'd1,
        A_IN_EN    = 4'd2,
        A_INVERT   = 4'd3,
        A_FILT_EN  = 4'd4,
        A_EVT_EN   = 4'd5,
        A_CNT_EN   = 4'd6,
        A_FALL_SEL = 4'd7,
        A_RISE_STS = 4'd8,
        A_FALL_STS = 4'd9,
        A_LEVEL    = 4'd10,
        A_FILT_AMT = 4'd11
    } gpio_addr_e;

    localparam int NUM_CTRL = 8;
endpackage

// File: rtl/gpio_setclr_reg.sv
`timescale 1ns/1ps
// Module: one per-pin control register updated by an atomic set/clear word.
// Assumes set and clear masks are already split from the write word;
// clear wins over set on the same bit.
module gpio_setclr_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);
    // Apply set then clear on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_stb)
            q <= (q | set_bits) & ~clr_bits;
    end

    // R2: any bit named in the clear half is zero after the write.
    p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ((q & $past(clr_bits)) == '0));

    // R1: bits named in neither half keep their value.
    p_untouched_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ((q & ~$past(set_bits | clr_bits)) ==
                    ($past(q) & ~$past(set_bits | clr_bits))));
endmodule

// File: rtl/gpio_pin_filter.sv
`timescale 1ns/1ps
// Module: per-pin input path: two-flop synchronizer, receiver gate,
// invert and a counting glitch filter.
// Assumes amt is static while a level is being qualified; amt == 0 or
// filt_en == 0 passes the inverted level straight through.
module gpio_pin_filter #(
    parameter int AMT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             in_en,
    input  logic             inv,
    input  logic             filt_en,
    input  logic [AMT_W-1:0] amt,
    output logic             level,
    output logic             sensed
);
    logic             s1, s2;
    logic             inv_lvl, bypass, held;
    logic [AMT_W-1:0] cnt;
    logic [1:0]       since_rst;

    // Two-flop synchronizer for the asynchronous pad input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= raw;
            s2 <= s1;
        end
    end

    assign level   = s2 & in_en;
    assign inv_lvl = level ^ inv;
    assign bypass  = !filt_en || (amt == '0);

    // Glitch filter: accept a new level after it has differed for amt cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            cnt  <= '0;
        end else if (bypass) begin
            held <= inv_lvl;
            cnt  <= '0;
        end else if (inv_lvl == held) begin
            cnt <= '0;
        end else if (cnt == amt - AMT_W'(1)) begin
            held <= inv_lvl;
            cnt  <= '0;
        end else begin
            cnt <= cnt + AMT_W'(1);
        end
    end

    assign sensed = bypass ? inv_lvl : held;

    // Count edges since reset so the latency check starts only on valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    // R5: the synchronized level is the pad value from two edges earlier.
    p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (s2 == $past(raw, 2)));

    // R11: the filtered level only ever moves to the level seen a cycle before.
    p_filt_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && held != $past(held)) |-> (held == $past(inv_lvl)));
endmodule

// File: rtl/gpio_edge_status.sv
`timescale 1ns/1ps
// Module: edge detection, rise/fall status with write-one-to-clear,
// and the merged interrupt.
// Assumes sensed levels are synchronous; a new edge beats a clear.
module gpio_edge_status #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sensed,
    input  logic [W-1:0] evt_en,
    input  logic [W-1:0] fall_sel,
    input  logic         clr_rise_stb,
    input  logic         clr_fall_stb,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] rise_sts,
    output logic [W-1:0] fall_sts,
    output logic         irq
);
    logic [W-1:0] prev, set_rise, set_fall, rise_clr, fall_clr;

    assign set_rise = sensed & ~prev & evt_en & ~fall_sel;
    assign set_fall = ~sensed & prev & evt_en & fall_sel;
    assign rise_clr = clr_rise_stb ? clr_mask : '0;
    assign fall_clr = clr_fall_stb ? clr_mask : '0;

    // Remember last sensed level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev <= '0;
        else
            prev <= sensed;
    end

    // Status update: clear requested bits, then record new edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_sts <= '0;
            fall_sts <= '0;
        end else begin
            rise_sts <= (rise_sts & ~rise_clr) | set_rise;
            fall_sts <= (fall_sts & ~fall_clr) | set_fall;
        end
    end

    assign irq = |(evt_en & (rise_sts | fall_sts));

    // R8: a status bit never rises for a pin whose events were disabled.
    p_no_evt_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((rise_sts | fall_sts) & ~$past(rise_sts | fall_sts) & ~$past(evt_en)) == '0));

    // R9: a written 1 clears the bit unless an edge arrived that cycle.
    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rise_stb |=> ((rise_sts & $past(clr_mask) & ~$past(set_rise)) == '0));

    // R9: an edge in the clearing cycle survives.
    p_edge_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall_stb |=> ((fall_sts & $past(set_fall)) == $past(set_fall)));

    // R10: the interrupt needs a pending status bit.
    p_irq_has_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((rise_sts | fall_sts) != '0));
endmodule

// File: rtl/gpio_atomic_bank.sv
`timescale 1ns/1ps
// Module: top of the GPIO bank: write decode, control registers,
// per-pin input paths, edge status and read mux.
// Assumes single-cycle writes and a combinational read port.
module gpio_atomic_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPIN  = 16,
    parameter int AMT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [3:0]          wr_addr,
    input  logic [2*NPIN-1:0]   wr_data,
    input  logic [3:0]          rd_addr,
    output logic [2*NPIN-1:0]   rd_data,
    input  logic [NPIN-1:0]     pin_in,
    output logic [NPIN-1:0]     pin_out,
    output logic [NPIN-1:0]     pin_oe,
    output logic                irq
);
    localparam int WORD_W = 2 * NPIN;

    logic [NUM_CTRL-1:0][NPIN-1:0] ctrl_q;
    logic [NPIN-1:0]  set_half, clr_half;
    logic [NPIN-1:0]  level_bus, sensed_bus, rise_sts, fall_sts;
    logic [AMT_W-1:0] filt_amt;
    logic             clr_rise_stb, clr_fall_stb;

    assign set_half = wr_data[NPIN-1:0];
    assign clr_half = wr_data[WORD_W-1:NPIN];

    // One atomic set/clear register per control function.
    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
        gpio_setclr_reg #(.W(NPIN)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (wr_en && (wr_addr == 4'(k))),
            .set_bits (set_half),
            .clr_bits (clr_half),
            .q        (ctrl_q[k])
        );
    end

    // Filter amount is a plain (non-atomic) register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            filt_amt <= '0;
        else if (wr_en && wr_addr == A_FILT_AMT)
            filt_amt <= wr_data[AMT_W-1:0];
    end

    assign clr_rise_stb = wr_en && (wr_addr == A_RISE_STS);
    assign clr_fall_stb = wr_en && (wr_addr == A_FALL_STS);

    // Per-pin synchronizer, gate, invert and filter.
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        gpio_pin_filter #(.AMT_W(AMT_W)) u_in (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (pin_in[p]),
            .in_en   (ctrl_q[A_IN_EN][p]),
            .inv     (ctrl_q[A_INVERT][p]),
            .filt_en (ctrl_q[A_FILT_EN][p]),
            .amt     (filt_amt),
            .level   (level_bus[p]),
            .sensed  (sensed_bus[p])
        );
    end

    gpio_edge_status #(.W(NPIN)) u_sts (
        .clk          (clk),
        .rst_n        (rst_n),
        .sensed       (sensed_bus),
        .evt_en       (ctrl_q[A_EVT_EN]),
        .fall_sel     (ctrl_q[A_FALL_SEL]),
        .clr_rise_stb (clr_rise_stb),
        .clr_fall_stb (clr_fall_stb),
        .clr_mask     (set_half),
        .rise_sts     (rise_sts),
        .fall_sts     (fall_sts),
        .irq          (irq)
    );

    assign pin_out = ctrl_q[A_OUT_VAL];
    assign pin_oe  = ctrl_q[A_OUT_EN];

    // Read mux: 16-bit values zero-extended to the word.
    always_comb begin
        rd_data = '0;
        if (rd_addr < 4'(NUM_CTRL))
            rd_data[NPIN-1:0] = ctrl_q[rd_addr[2:0]];
        else if (rd_addr == A_RISE_STS)
            rd_data[NPIN-1:0] = rise_sts;
        else if (rd_addr == A_FALL_STS)
            rd_data[NPIN-1:0] = fall_sts;
        else if (rd_addr == A_LEVEL)
            rd_data[NPIN-1:0] = level_bus;
        else if (rd_addr == A_FILT_AMT)
            rd_data[AMT_W-1:0] = filt_amt;
    end

    // R3: the upper half of every read is zero.
    p_read_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (rd_data[WORD_W-1:NPIN] == '0));

    // R4: a pin with its receiver off never reads high in readback.
    p_rx_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((level_bus & ~ctrl_q[A_IN_EN]) == '0));
endmodule

// File: tb/gpio_atomic_bank_test.sv
`timescale 1ns/1ps
module gpio_atomic_bank_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_addr, rd_addr;
    logic [31:0] wr_data, rd_data;
    logic [15:0] pin_in, pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] ctrl [8];

    always #2.5 clk = ~clk;

    gpio_atomic_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [15:0] setclr(logic [15:0] old, logic [31:0] d);
        return (old | d[15:0]) & ~d[31:16];
    endfunction

    function automatic logic [15:0] sense(logic [15:0] p);
        return (p & ctrl[2]) ^ ctrl[3];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4'd8) ctrl[a[2:0]] = setclr(ctrl[a[2:0]], d);
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
        rd_addr = a;
        #0.5;
        check(req, rd_data, exp);
    endtask

    task automatic put(int a, logic [15:0] v);
        wr(4'(a), {~v, v});
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] exp_r, exp_f, lvl, nl, pins;
        void'($urandom(32'd20250611));
        for (int i = 0; i < 8; i++) ctrl[i] = '0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; pin_in = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R3 R12: reset values and unused addresses read zero
        for (int a = 0; a < 16; a++) rd_chk("R3 reset", 4'(a), 32'h0);
        check("R3 reset irq/oe", {15'h0, irq, pin_oe}, 32'h0);

        // R1 R2: random atomic writes against the bench model
        for (int i = 0; i < 60; i++) begin
            int a = $urandom % 8;
            logic [31:0] d = $urandom;
            if (i % 4 == 0) d[31:16] = d[31:16] | (d[15:0] & 16'h0F0F);
            wr(4'(a), d);
            rd_chk("R1 random set/clear", 4'(a), {16'h0, ctrl[a]});
        end
        check("R3 pin_out", {16'h0, pin_out}, {16'h0, ctrl[0]});
        check("R3 pin_oe", {16'h0, pin_oe}, {16'h0, ctrl[1]});
        wr(4'd6, 32'h0000_FFFF);
        wr(4'd6, 32'h00FF_00FF);
        rd_chk("R2 clear wins", 4'd6, 32'h0000_FF00);
        wr(4'd6, 32'h0);
        rd_chk("R1 zero write keeps", 4'd6, 32'h0000_FF00);
        wr(4'd12, 32'h0000_FFFF);
        rd_chk("R12 unused address", 4'd12, 32'h0);
        for (int a = 0; a < 8; a++) wr(4'(a), 32'hFFFF_0000);

        // R5 R4: readback latency and receiver gate
        put(2, 16'hFFFF);
        @(negedge clk) pin_in = 16'hA5C3;
        step(1);
        rd_chk("R5 readback not yet", 4'd10, 32'h0);
        step(1);
        rd_chk("R5 readback after two edges", 4'd10, 32'h0000_A5C3);
        rd_chk("R5 readback repeat read", 4'd10, 32'h0000_A5C3);
        put(3, 16'h00FF);
        rd_chk("R7 readback ignores invert", 4'd10, 32'h0000_A5C3);
        put(2, 16'hFF00);
        rd_chk("R4 receiver off reads 0", 4'd10, 32'h0000_A500);

        // R6 R7 R8 R10 R4: random configurations and pin patterns
        for (int r = 0; r < 6; r++) begin
            put(2, 16'($urandom)); put(3, 16'($urandom));
            put(5, 16'($urandom)); put(7, 16'($urandom));
            put(4, 16'h0);
            step(6);
            wr(4'd8, 32'h0000_FFFF); wr(4'd9, 32'h0000_FFFF);
            exp_r = '0; exp_f = '0;
            lvl = sense(pin_in);
            rd_chk("R9 cleared", 4'd8, 32'h0);
            for (int k = 0; k < 8; k++) begin
                pins = 16'($urandom);
                @(negedge clk) pin_in = pins;
                step(4);
                nl = sense(pins);
                exp_r |= nl & ~lvl & ctrl[5] & ~ctrl[7];
                exp_f |= ~nl & lvl & ctrl[5] & ctrl[7];
                lvl = nl;
                rd_chk("R6 R7 R8 rise status", 4'd8, {16'h0, exp_r});
                rd_chk("R6 R7 R8 fall status", 4'd9, {16'h0, exp_f});
                check("R10 irq", {31'h0, irq}, {31'h0, |(ctrl[5] & (exp_r | exp_f))});
            end
        end

        // R9 R10: directed clear behaviour
        put(2, 16'hFFFF); put(3, 16'h0); put(5, 16'hFFFF); put(7, 16'h0);
        @(negedge clk) pin_in = 16'h0;
        step(6);
        wr(4'd8, 32'h0000_FFFF); wr(4'd9, 32'h0000_FFFF);
        @(negedge clk) pin_in = 16'h0003;
        step(4);
        rd_chk("R6 rise status two pins", 4'd8, 32'h0000_0003);
        wr(4'd8, 32'h0);
        rd_chk("R9 write zero no effect", 4'd8, 32'h0000_0003);
        wr(4'd8, 32'h0000_0001);
        rd_chk("R9 write one clears", 4'd8, 32'h0000_0002);
        check("R10 irq pending", {31'h0, irq}, 32'h1);
        put(5, 16'hFFFD);
        check("R10 irq masked by evt enable", {31'h0, irq}, 32'h0);
        rd_chk("R10 status kept while masked", 4'd8, 32'h0000_0002);
        put(5, 16'hFFFF);
        wr(4'd8, 32'h0000_FFFF);

        // R7: inverted pin 4 reports a rise on pad fall
        put(3, 16'h0010);
        step(5);
        wr(4'd8, 32'h0000_FFFF);
        @(negedge clk) pin_in = 16'h0013;
        step(4);
        rd_chk("R7 pad rise inverted no rise", 4'd8, 32'h0);
        @(negedge clk) pin_in = 16'h0003;
        step(4);
        rd_chk("R7 pad fall inverted gives rise", 4'd8, 32'h0000_0010);
        put(3, 16'h0);
        step(5);
        wr(4'd8, 32'h0000_FFFF);

        // R6: falling polarity on pin 5, with the exact cycle
        put(7, 16'h0020);
        @(negedge clk) pin_in = 16'h0023;
        step(4);
        check("R6 rise ignored under fall select", rd_data, 32'h0);
        @(negedge clk) pin_in = 16'h0003;
        step(2);
        rd_chk("R6 fall not before third edge", 4'd9, 32'h0);
        step(1);
        rd_chk("R6 fall on third edge", 4'd9, 32'h0000_0020);
        put(7, 16'h0);
        wr(4'd9, 32'h0000_FFFF);

        // R11: filter amount 3 on pin 8
        wr(4'd11, 32'h0000_0003);
        rd_chk("R11 amount readback", 4'd11, 32'h0000_0003);
        put(4, 16'h0100);
        step(3);
        @(negedge clk) pin_in = 16'h0103;
        step(2);
        pin_in = 16'h0003;
        step(8);
        rd_chk("R11 short pulse dropped", 4'd8, 32'h0);
        @(negedge clk) pin_in = 16'h0103;
        step(5);
        rd_chk("R11 not before A cycles", 4'd8, 32'h0);
        step(1);
        rd_chk("R11 accepted after A cycles", 4'd8, 32'h0000_0100);
        wr(4'd11, 32'h0);
        @(negedge clk) pin_in = 16'h0003;
        step(4);
        wr(4'd8, 32'h0000_FFFF);
        @(negedge clk) pin_in = 16'h0103;
        step(3);
        rd_chk("R11 amount zero no delay", 4'd8, 32'h0000_0100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule